// File: doc/BRIEF.md
# Serial DMA Channel Request/Grant Host Link

This block is the host end of a serial channel-passing link for DMA. Each attached expansion agent owns one request pin and one grant pin, and both pins run on the host clock. When an agent wants service it sends a request frame on its request pin. The frame is a start bit followed by one slot per DMA channel. The block decodes the frame into a bitmap of pending channels. Any channel whose configuration field does not choose the serial-pair style is removed from the bitmap, and the result is presented to an outside arbiter.

The arbiter names a pair and a channel. If that pair's grant serializer is idle and the named channel is pending, the block sends the channel number back on the grant pin, least significant bit first. It then raises a one-cycle completion pulse that carries the channel number. The DMA engine uses this pulse to start its two-step transfer, which reads the peripheral and then writes memory.

The number of pairs is a parameter. The default is two pairs, A and B, on indices 0 and 1. Each pair has its own receiver, pending bitmap and serializer.

Top module: `sdma_link_host`

## Requirements
- R1: While reset is low, and in the first cycle after it, every grant pin is high, every pending bit is clear, every completion pulse is low and every pair reports ready.
- R2: A request frame is one low clock (the start bit) on an idle-high request pin, followed by eight slots for channels 0 to 7 in that order. A low slot means the channel is requesting. The pending bits of the frame's channels become visible on `chan_req[p*8+c]` in the cycle after the slot for channel 7 has been sampled.
- R3: The 16-bit `style_cfg` input has seven 2-bit fields. Channel c < 4 uses bits [2c+1:2c], and channel c > 4 uses bits [2c-1:2c-2]. A channel is captured as pending only when its field equals `SERIAL_SEL` (default 2'b01) at the clock edge that completes the frame. Bits [15:14] are unused.
- R4: Channel 4 has no field and is never pending. A request in slot 4 is ignored.
- R5: A grant accepted at a clock edge drives the grant pin low for one cycle (the start bit). The pin then carries channel bits 0, 1 and 2 in turn, with a 1 driven as low and a 0 as high, and then returns high. For example, channel 1 gives low, low, high, high and channel 6 gives low, high, low, low.
- R6: A grant is accepted only when `arb_valid` is high, `arb_pair` names the pair, the pair's serializer is idle (`arb_ready` high) and the named channel is pending. In every other case nothing happens on the grant pin, and the pending bitmap is not changed.
- R7: The pending bit of an accepted channel is cleared at the accepting edge.
- R8: On the edge where the grant pin returns high, `gnt_done[p]` pulses for exactly one cycle and `gnt_done_chan` holds the granted channel number.
- R9: The pairs run independently. Traffic on one pair never changes another pair's pending bits or grant pin.
- R10: Successive request frames on a pair accumulate: newly captured bits are ORed into the bits that are already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock shared by all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| style_cfg | input | 16 | Per-channel DMA style fields |
| req_n | input | NUM_PAIRS | Serial request pins, active low, idle high |
| gnt_n | output | NUM_PAIRS | Serial grant pins, active low, idle high |
| chan_req | output | 8*NUM_PAIRS | Pending channel bitmap per pair, bit p*8+c |
| arb_valid | input | 1 | Arbiter offers a grant this cycle |
| arb_pair | input | PAIR_W | Pair chosen by the arbiter |
| arb_chan | input | 3 | Channel chosen by the arbiter |
| arb_ready | output | NUM_PAIRS | Serializer of the pair is idle |
| gnt_done | output | NUM_PAIRS | One-cycle pulse when a grant frame ends |
| gnt_done_chan | output | 3*NUM_PAIRS | Channel of the finished grant, per pair |

## Verification
The assertions assume the following about the block's inputs:
- Request pins stay high between frames.
- A new start bit never arrives while a frame on the same pin is still in its slots.
- `style_cfg` is held steady while a frame is being captured.

The directed stimulus keeps to these assumptions. It releases each request pin after the channel 7 slot, it changes the configuration only between frames, and it presents arbiter choices one cycle at a time. The properties then check the start bit and the clearing of the pending bit after each accept, the style check on every rising pending bit, the permanent absence of channel 4, and the single-cycle completion pulse.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   localparam int CH_NUM      = 8;
   localparam int CH_W        = $clog2(CH_NUM);
   localparam int FIELD_W     = 2;
   localparam int CFG_W       = 16;
   localparam int NO_FIELD_CH = 4;
   localparam int GNT_STEPS   = CH_W + 1;

   typedef logic [CH_W-1:0]   chan_t;
   typedef logic [CH_NUM-1:0] chmap_t;
endpackage

// File: rtl/sdma_style_mask.sv
module sdma_style_mask
   import sdma_pkg::*;
#(
   parameter logic [FIELD_W-1:0] SERIAL_SEL = 2'b01
) (
   input  logic [CFG_W-1:0] style_cfg,
   output chmap_t           allow
);
   for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      if (c == NO_FIELD_CH) begin : g_none
         assign allow[c] = 1'b0;
      end else begin : g_field
         localparam int IDX = (c < NO_FIELD_CH) ? c : c - 1;
         assign allow[c] = (style_cfg[IDX*FIELD_W +: FIELD_W] == SERIAL_SEL);
      end
   end
endmodule

// File: rtl/sdma_req_rx.sv
module sdma_req_rx
   import sdma_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_n,
   input  chmap_t allow,
   input  logic   clr_en,
   input  chan_t  clr_chan,
   output chmap_t pending
);
   logic   active;
   chan_t  slot;
   chmap_t bits;
   chmap_t frame_bits;
   chmap_t clr_vec;
   logic   frame_end;

   always_comb begin
      frame_bits = bits;
      frame_bits[CH_NUM-1] = ~req_n;
      frame_end = active && (slot == chan_t'(CH_NUM-1));
      clr_vec = '0;
      if (clr_en) clr_vec[clr_chan] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         slot    <= '0;
         bits    <= '0;
         pending <= '0;
      end else begin
         if (!active) begin
            if (!req_n) begin
               active <= 1'b1;
               slot   <= '0;
            end
         end else begin
            bits[slot] <= ~req_n;
            if (frame_end) active <= 1'b0;
            else           slot   <= slot + 1'b1;
         end
         pending <= (pending | (frame_end ? (frame_bits & allow) : '0)) & ~clr_vec;
      end
   end
endmodule

// File: rtl/sdma_gnt_tx.sv
module sdma_gnt_tx
   import sdma_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  chan_t load_chan,
   output logic  ready,
   output logic  gnt_n,
   output logic  done,
   output chan_t done_chan
);
   localparam int PH_W = $clog2(GNT_STEPS + 1);

   logic [PH_W-1:0] phase;
   chan_t           chan_q;
   chan_t           shift_q;

   assign ready = (phase == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         chan_q    <= '0;
         shift_q   <= '0;
         gnt_n     <= 1'b1;
         done      <= 1'b0;
         done_chan <= '0;
      end else begin
         done <= 1'b0;
         if (phase == '0) begin
            if (load) begin
               gnt_n   <= 1'b0;
               chan_q  <= load_chan;
               shift_q <= load_chan;
               phase   <= PH_W'(1);
            end
         end else if (phase <= PH_W'(CH_W)) begin
            gnt_n   <= ~shift_q[0];
            shift_q <= shift_q >> 1;
            phase   <= phase + 1'b1;
         end else begin
            gnt_n     <= 1'b1;
            done      <= 1'b1;
            done_chan <= chan_q;
            phase     <= '0;
         end
      end
   end
endmodule

// File: rtl/sdma_link_host.sv
module sdma_link_host
   import sdma_pkg::*;
#(
   parameter int                 NUM_PAIRS  = 2,
   parameter logic [FIELD_W-1:0] SERIAL_SEL = 2'b01,
   localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CFG_W-1:0]          style_cfg,
   input  logic [NUM_PAIRS-1:0]      req_n,
   output logic [NUM_PAIRS-1:0]      gnt_n,
   output logic [NUM_PAIRS*CH_NUM-1:0] chan_req,
   input  logic                      arb_valid,
   input  logic [PAIR_W-1:0]         arb_pair,
   input  logic [CH_W-1:0]           arb_chan,
   output logic [NUM_PAIRS-1:0]      arb_ready,
   output logic [NUM_PAIRS-1:0]      gnt_done,
   output logic [NUM_PAIRS*CH_W-1:0] gnt_done_chan
);
   if (NUM_PAIRS < 1 || NUM_PAIRS > 4) begin : g_bad_pairs
      $error("sdma_link_host: NUM_PAIRS must be 1..4");
   end
   if ((CH_NUM - 1) * FIELD_W > CFG_W) begin : g_bad_cfg
      $error("sdma_link_host: style fields exceed configuration width");
   end
   if (NO_FIELD_CH >= CH_NUM) begin : g_bad_hole
      $error("sdma_link_host: fieldless channel out of range");
   end

   chmap_t allow;

   sdma_style_mask #(.SERIAL_SEL(SERIAL_SEL)) u_mask (
      .style_cfg (style_cfg),
      .allow     (allow)
   );

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      chmap_t pend;
      chan_t  dchan;
      logic   load;

      assign load = arb_valid && (arb_pair == PAIR_W'(p)) && arb_ready[p]
                    && pend[arb_chan];

      sdma_req_rx u_rx (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_n    (req_n[p]),
         .allow    (allow),
         .clr_en   (load),
         .clr_chan (arb_chan),
         .pending  (pend)
      );

      sdma_gnt_tx u_tx (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .load_chan (arb_chan),
         .ready     (arb_ready[p]),
         .gnt_n     (gnt_n[p]),
         .done      (gnt_done[p]),
         .done_chan (dchan)
      );

      assign chan_req[p*CH_NUM +: CH_NUM]    = pend;
      assign gnt_done_chan[p*CH_W +: CH_W]   = dchan;
   end
endmodule

// File: rtl/sdma_link_host_chk.sv
module sdma_link_host_chk
   import sdma_pkg::*;
#(
   parameter int                 NUM_PAIRS  = 2,
   parameter logic [FIELD_W-1:0] SERIAL_SEL = 2'b01,
   localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [CFG_W-1:0]            style_cfg,
   input logic [NUM_PAIRS-1:0]        req_n,
   input logic [NUM_PAIRS-1:0]        gnt_n,
   input logic [NUM_PAIRS*CH_NUM-1:0] chan_req,
   input logic                        arb_valid,
   input logic [PAIR_W-1:0]           arb_pair,
   input logic [CH_W-1:0]             arb_chan,
   input logic [NUM_PAIRS-1:0]        arb_ready,
   input logic [NUM_PAIRS-1:0]        gnt_done,
   input logic [NUM_PAIRS*CH_W-1:0]   gnt_done_chan
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
      assert_no_ch4_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_req[p*CH_NUM + NO_FIELD_CH]);

      assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_done[p] |=> !gnt_done[p]);

      assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         gnt_done[p] |-> gnt_n[p]);

      assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(arb_ready[p]) |-> !gnt_n[p]);

      for (genvar c = 0; c < CH_NUM; c++) begin : g_c
         assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (arb_valid && arb_pair == PAIR_W'(p) && arb_chan == CH_W'(c)
             && arb_ready[p] && chan_req[p*CH_NUM + c]) |=> !gnt_n[p]);

         assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (arb_valid && arb_pair == PAIR_W'(p) && arb_chan == CH_W'(c)
             && arb_ready[p] && chan_req[p*CH_NUM + c]) |=> !chan_req[p*CH_NUM + c]);

         if (c != NO_FIELD_CH) begin : g_f
            localparam int IDX = (c < NO_FIELD_CH) ? c : c - 1;
            assert_style_R3: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(chan_req[p*CH_NUM + c]) |->
                  ($past(style_cfg[IDX*FIELD_W +: FIELD_W]) == SERIAL_SEL));
         end
      end
   end
endmodule

bind sdma_link_host sdma_link_host_chk #(
   .NUM_PAIRS  (NUM_PAIRS),
   .SERIAL_SEL (SERIAL_SEL)
) u_chk (.*);

// File: tb/tb_sdma_link_host.sv
module tb_sdma_link_host;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] style_cfg;
   logic [1:0]  req_n;
   logic [1:0]  gnt_n;
   logic [15:0] chan_req;
   logic        arb_valid;
   logic [0:0]  arb_pair;
   logic [2:0]  arb_chan;
   logic [1:0]  arb_ready;
   logic [1:0]  gnt_done;
   logic [5:0]  gnt_done_chan;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_pend [2];

   always #4 clk = ~clk;

   sdma_link_host dut (
      .clk(clk), .rst_n(rst_n), .style_cfg(style_cfg), .req_n(req_n),
      .gnt_n(gnt_n), .chan_req(chan_req), .arb_valid(arb_valid),
      .arb_pair(arb_pair), .arb_chan(arb_chan), .arb_ready(arb_ready),
      .gnt_done(gnt_done), .gnt_done_chan(gnt_done_chan)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // builds the configuration word from per-channel 2-bit codes (R3 layout)
   function automatic logic [15:0] mk_cfg(input logic [1:0] code [8]);
      logic [15:0] w = '0;
      for (int c = 0; c < 8; c++) begin
         if (c < 4)      w[2*c +: 2]     = code[c];
         else if (c > 4) w[2*c-2 +: 2]   = code[c];
      end
      return w;
   endfunction

   task automatic check_pend(input string tag);
      chk(chan_req[7:0]  == exp_pend[0], tag, chan_req[7:0],  exp_pend[0]);
      chk(chan_req[15:8] == exp_pend[1], tag, chan_req[15:8], exp_pend[1]);
   endtask

   task automatic send_frame(input int p, input logic [7:0] map);
      @(negedge clk) req_n[p] = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk) req_n[p] = ~map[k];
      end
      @(negedge clk) req_n[p] = 1'b1;
   endtask

   task automatic do_grant(input int p, input logic [2:0] ch, input bit acc, input string tag);
      logic [4:0] seq;
      logic [4:0] dn;
      logic [2:0] dch;
      logic [4:0] exp_seq;
      @(negedge clk);
      arb_valid = 1'b1; arb_pair = 1'(p); arb_chan = ch;
      for (int s = 0; s < 5; s++) begin
         @(negedge clk);
         if (s == 0) arb_valid = 1'b0;
         seq[s] = gnt_n[p];
         dn[s]  = gnt_done[p];
         if (s == 4) dch = gnt_done_chan[p*3 +: 3];
      end
      exp_seq = acc ? {1'b1, ~ch[2], ~ch[1], ~ch[0], 1'b0} : 5'b11111;
      chk(seq == exp_seq, {tag, " grant pin sequence"}, seq, exp_seq);
      chk(dn == (acc ? 5'b10000 : 5'b00000), {tag, " done pulse"}, dn, acc ? 5'b10000 : 5'b0);
      if (acc) begin
         chk(dch == ch, {tag, " done channel"}, dch, ch);
         exp_pend[p][ch] = 1'b0;
      end
      check_pend({tag, " pending after grant"});
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(gnt_n == 2'b11, "R1 grant pins idle", gnt_n, 2'b11);
      chk(chan_req == '0, "R1 pending clear", chan_req, 0);
      chk(gnt_done == '0, "R1 done low", gnt_done, 0);
      chk(arb_ready == 2'b11, "R1 ready", arb_ready, 2'b11);
   endtask

   task automatic t_decode_mask();
      send_frame(0, 8'hFF);
      exp_pend[0] = 8'h6B;
      check_pend("R2 R3 R4 full frame masked");
   endtask

   task automatic t_busy();
      logic [3:0] seq;
      @(negedge clk);
      arb_valid = 1'b1; arb_pair = 1'b0; arb_chan = 3'd0;
      @(negedge clk);
      chk(arb_ready[0] == 1'b0, "R6 ready low while shifting", arb_ready[0], 0);
      seq[0] = gnt_n[0];
      arb_chan = 3'd3;
      @(negedge clk);
      arb_valid = 1'b0;
      seq[1] = gnt_n[0];
      @(negedge clk) seq[2] = gnt_n[0];
      @(negedge clk) seq[3] = gnt_n[0];
      chk(seq == 4'b1110, "R6 busy grant sequence", seq, 4'b1110);
      @(negedge clk);
      chk(gnt_done[0] && gnt_done_chan[2:0] == 3'd0, "R8 busy done channel", gnt_done_chan[2:0], 0);
      exp_pend[0][0] = 1'b0;
      check_pend("R6 second offer ignored");
   endtask

   task automatic t_pair_b();
      send_frame(1, 8'h10);
      check_pend("R4 slot 4 only ignored");
      send_frame(1, 8'h08);
      send_frame(1, 8'h20);
      exp_pend[1] = 8'h28;
      check_pend("R10 R9 accumulate on pair B");
      chk(gnt_n[0] == 1'b1, "R9 pair A pin untouched", gnt_n[0], 1);
      do_grant(1, 3'd5, 1'b1, "R9 R5 pair B ch5");
   endtask

   task automatic t_cfg_off();
      logic [1:0] code [8];
      for (int c = 0; c < 8; c++) code[c] = 2'b01;
      code[1] = 2'b11;
      style_cfg = mk_cfg(code);
      send_frame(1, 8'h03);
      exp_pend[1][0] = 1'b1;
      check_pend("R3 field 11 masked, ch0 kept");
   endtask

   initial begin
      logic [1:0] code [8];
      rst_n = 1'b0; req_n = 2'b11; arb_valid = 1'b0; arb_pair = '0; arb_chan = '0;
      for (int c = 0; c < 8; c++) code[c] = 2'b01;
      code[2] = 2'b10; code[7] = 2'b00;
      style_cfg = mk_cfg(code);
      exp_pend[0] = '0; exp_pend[1] = '0;
      repeat (3) @(negedge clk);
      chk(gnt_n == 2'b11 && chan_req == '0, "R1 during reset", {gnt_n, chan_req}, 18'h30000);
      rst_n = 1'b1;
      t_reset();
      t_decode_mask();
      do_grant(0, 3'd1, 1'b1, "R5 R7 R8 ch1");
      do_grant(0, 3'd6, 1'b1, "R5 R7 R8 ch6");
      do_grant(0, 3'd2, 1'b0, "R6 not pending ch2");
      do_grant(0, 3'd4, 1'b0, "R4 R6 ch4 offer");
      t_busy();
      t_pair_b();
      t_cfg_off();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule